// File: doc/BRIEF.md
# Reset-Sampled Boot Vector Selector

This block gives a processor subsystem its first instruction-fetch address. On every clock edge while the subsystem reset is high, it copies a 4-bit boot-mode code and the upper 22 bits of a 32-bit boot-address word from the system control registers into shadow registers. When reset drops, the copy stops and the captured values stay frozen until the next reset. Later edits to the control registers have no effect until then.

A zero mode starts execution at the captured address, aligned to 1 KB. Any other mode starts execution at the fixed ROM loader entry 0x007E0000. The block also presents the captured mode as one-hot flags that the ROM loader branches on. The shadow values can be read back through a small register port. Only the local CPU may read them. Reads from any other requester return zero and raise an error pulse. Writes from any requester change nothing.

Top module: `boot_vector_sel`

## Requirements
- R1: On each rising edge with `rst` high, the shadow registers load `ctl_mode_i` and `ctl_addr_i[31:10]`. The values held after release are those of the last edge with `rst` high. Input changes after release do not alter the vector, the flags or the read-back value until the next reset.
- R2: At the first rising edge with `rst` low, `vec_valid_o`, `fetch_vec_o` and the mode flags take their post-boot values. They are visible after that edge.
- R3: With a captured mode of 0, `fetch_vec_o` equals the captured `ctl_addr_i[31:10]` with bits [9:0] zero, and all five mode flags are low.
- R4: With any captured mode from 1 to 15, `fetch_vec_o` equals 32'h007E0000.
- R5: The flags decode as follows: mode 1 gives `boot_idle_o`, mode 2 gives `boot_spin_o`, mode 3 gives `boot_cache_o`, mode 4 gives `boot_user_o`, and modes 5 to 15 give `boot_rsvd_o`. At most one flag is high at any time.
- R6: After an edge with `rst` high, `fetch_vec_o`, `vec_valid_o`, all flags, `rd_data_o` and `rd_err_o` are zero. Once set, `vec_valid_o` stays high until the next reset.
- R7: A read by requester 0 (`req_id_i` = 0) returns data on `rd_data_o` after the next edge. With `rd_sel_i` = 0 the data is the mode, zero-extended. With `rd_sel_i` = 1 the data is the captured address with bits [9:0] zero. With no read, `rd_data_o` is zero.
- R8: A read by any nonzero `req_id_i` returns zero on `rd_data_o` and sets `rd_err_o` for exactly that one cycle.
- R9: Asserting `wr_en_i` with any `wr_data_i` and any requester changes neither the vector, the flags nor the read-back values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high subsystem reset; parameters are sampled while it is high |
| ctl_mode_i | input | 4 | Live boot-mode control value |
| ctl_addr_i | input | 32 | Live boot-address control value; bits [9:0] are not used |
| rd_en_i | input | 1 | Register read request |
| wr_en_i | input | 1 | Register write request (ignored) |
| req_id_i | input | 3 | Requester identity; 0 is the local CPU |
| rd_sel_i | input | 1 | Read select: 0 mode, 1 address |
| wr_data_i | input | 32 | Write data (ignored) |
| fetch_vec_o | output | 32 | First instruction-fetch address |
| vec_valid_o | output | 1 | Fetch vector is valid |
| boot_idle_o | output | 1 | Mode 1: configure then idle |
| boot_spin_o | output | 1 | Mode 2: self-loop wait |
| boot_cache_o | output | 1 | Mode 3: cache configuration |
| boot_user_o | output | 1 | Mode 4: user bootstrap copied to local memory and branched to |
| boot_rsvd_o | output | 1 | Modes 5 to 15: reserved |
| rd_data_o | output | 32 | Read data |
| rd_err_o | output | 1 | One-cycle access error for a non-CPU read |

## Verification
Two events can land on the same clock edge: the release of reset and a change of the live control values. The bench drops `rst` and scrambles `ctl_mode_i` and `ctl_addr_i` in the same half-cycle. It then requires the vector, the flags and the read-back values to match the values held before the release, never the scrambled ones. A second overlap is a write, or a read by a foreign requester, issued while the frozen vector is on the outputs. The bench judges it by reading back through the CPU path and by checking that `fetch_vec_o` does not move.

// File: rtl/boot_vec_pkg.sv
package boot_vec_pkg;
  localparam logic [31:0] ROM_ENTRY_DEF = 32'h007E_0000;
  localparam int NUM_MODES = 4;

  typedef enum logic {
    SEL_MODE = 1'b0,
    SEL_ADDR = 1'b1
  } rd_sel_e;
endpackage

// File: rtl/boot_shadow_capture.sv
module boot_shadow_capture #(
  parameter int MODE_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 10,
  localparam int BASE_W    = ADDR_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] ctl_mode,
  input  logic [ADDR_W-1:0] ctl_addr,
  output logic [MODE_W-1:0] mode_q,
  output logic [BASE_W-1:0] base_q
);
  logic [ALIGN_BITS-1:0] unused_low;
  assign unused_low = ctl_addr[ALIGN_BITS-1:0];

  // Track the live values during reset; freeze on release.
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= ctl_mode;
      base_q <= ctl_addr[ADDR_W-1:ALIGN_BITS];
    end
  end
endmodule

// File: rtl/boot_mode_decode.sv
module boot_mode_decode #(
  parameter int MODE_W    = 4,
  parameter int NUM_CODES = 4
) (
  input  logic [MODE_W-1:0]  mode,
  output logic [NUM_CODES:0] flags
);
  // flags[k-1] is code k; flags[NUM_CODES] covers every code above NUM_CODES.
  for (genvar k = 1; k <= NUM_CODES; k++) begin : g_code
    assign flags[k-1] = (mode == MODE_W'(k));
  end
  assign flags[NUM_CODES] = (mode > MODE_W'(NUM_CODES));
endmodule

// File: rtl/boot_vector_out.sv
module boot_vector_out #(
  parameter int              MODE_W     = 4,
  parameter int              ADDR_W     = 32,
  parameter int              ALIGN_BITS = 10,
  parameter int              NUM_CODES  = 4,
  parameter logic [ADDR_W-1:0] ROM_ENTRY = 32'h007E_0000,
  localparam int             BASE_W     = ADDR_W - ALIGN_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [MODE_W-1:0]  mode_q,
  input  logic [BASE_W-1:0]  base_q,
  input  logic [NUM_CODES:0] flags_d,
  output logic [ADDR_W-1:0]  fetch_vec,
  output logic               vec_valid,
  output logic [NUM_CODES:0] flags_q
);
  logic [ADDR_W-1:0] vec_d;
  assign vec_d = (mode_q == '0) ? {base_q, {ALIGN_BITS{1'b0}}} : ROM_ENTRY;

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_vec <= '0;
      vec_valid <= 1'b0;
      flags_q   <= '0;
    end else begin
      fetch_vec <= vec_d;
      vec_valid <= 1'b1;
      flags_q   <= flags_d;
    end
  end
endmodule

// File: rtl/boot_shadow_read.sv
module boot_shadow_read #(
  parameter int MODE_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 10,
  parameter int ID_W       = 3,
  parameter logic [ID_W-1:0] CPU_ID = '0,
  localparam int BASE_W    = ADDR_W - ALIGN_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ID_W-1:0]   req_id,
  input  logic              rd_sel,
  input  logic [MODE_W-1:0] mode_q,
  input  logic [BASE_W-1:0] base_q,
  output logic [ADDR_W-1:0] rd_data,
  output logic              rd_err
);
  import boot_vec_pkg::*;

  logic [ADDR_W-1:0] word;
  assign word = (rd_sel_e'(rd_sel) == SEL_ADDR) ? {base_q, {ALIGN_BITS{1'b0}}}
                                               : {{(ADDR_W-MODE_W){1'b0}}, mode_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_err  <= 1'b0;
    end else if (rd_en && req_id == CPU_ID) begin
      rd_data <= word;
      rd_err  <= 1'b0;
    end else begin
      rd_data <= '0;
      rd_err  <= rd_en;
    end
  end
endmodule

// File: rtl/boot_vector_sel.sv
module boot_vector_sel #(
  parameter int MODE_W     = 4,
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 10,
  parameter int ID_W       = 3,
  parameter logic [ID_W-1:0]   CPU_ID    = '0,
  parameter logic [ADDR_W-1:0] ROM_ENTRY = boot_vec_pkg::ROM_ENTRY_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] ctl_mode_i,
  input  logic [ADDR_W-1:0] ctl_addr_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  input  logic [ID_W-1:0]   req_id_i,
  input  logic              rd_sel_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  output logic [ADDR_W-1:0] fetch_vec_o,
  output logic              vec_valid_o,
  output logic              boot_idle_o,
  output logic              boot_spin_o,
  output logic              boot_cache_o,
  output logic              boot_user_o,
  output logic              boot_rsvd_o,
  output logic [ADDR_W-1:0] rd_data_o,
  output logic              rd_err_o
);
  localparam int NUM_CODES = boot_vec_pkg::NUM_MODES;
  localparam int BASE_W    = ADDR_W - ALIGN_BITS;

  logic [MODE_W-1:0]  mode_q;
  logic [BASE_W-1:0]  base_q;
  logic [NUM_CODES:0] flags_d;
  logic [NUM_CODES:0] flags_q;

  // Shadow registers take no writes.
  logic unused_wr;
  assign unused_wr = ^{wr_en_i, wr_data_i};

  boot_shadow_capture #(.MODE_W(MODE_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS)) u_cap (
    .clk(clk), .rst(rst), .ctl_mode(ctl_mode_i), .ctl_addr(ctl_addr_i),
    .mode_q(mode_q), .base_q(base_q)
  );

  boot_mode_decode #(.MODE_W(MODE_W), .NUM_CODES(NUM_CODES)) u_dec (
    .mode(mode_q), .flags(flags_d)
  );

  boot_vector_out #(
    .MODE_W(MODE_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS),
    .NUM_CODES(NUM_CODES), .ROM_ENTRY(ROM_ENTRY)
  ) u_vec (
    .clk(clk), .rst(rst), .mode_q(mode_q), .base_q(base_q), .flags_d(flags_d),
    .fetch_vec(fetch_vec_o), .vec_valid(vec_valid_o), .flags_q(flags_q)
  );

  boot_shadow_read #(
    .MODE_W(MODE_W), .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS),
    .ID_W(ID_W), .CPU_ID(CPU_ID)
  ) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en_i), .req_id(req_id_i), .rd_sel(rd_sel_i),
    .mode_q(mode_q), .base_q(base_q), .rd_data(rd_data_o), .rd_err(rd_err_o)
  );

  assign boot_idle_o  = flags_q[0];
  assign boot_spin_o  = flags_q[1];
  assign boot_cache_o = flags_q[2];
  assign boot_user_o  = flags_q[3];
  assign boot_rsvd_o  = flags_q[NUM_CODES];
endmodule

// File: rtl/boot_vector_sel_chk.sv
module boot_vector_sel_chk #(
  parameter int ADDR_W     = 32,
  parameter int ALIGN_BITS = 10,
  parameter int ID_W       = 3,
  parameter logic [ID_W-1:0]   CPU_ID    = '0,
  parameter logic [ADDR_W-1:0] ROM_ENTRY = 32'h007E_0000
) (
  input logic              clk,
  input logic              rst,
  input logic              rd_en_i,
  input logic [ID_W-1:0]   req_id_i,
  input logic [ADDR_W-1:0] fetch_vec_o,
  input logic              vec_valid_o,
  input logic              boot_idle_o,
  input logic              boot_spin_o,
  input logic              boot_cache_o,
  input logic              boot_user_o,
  input logic              boot_rsvd_o,
  input logic [ADDR_W-1:0] rd_data_o,
  input logic              rd_err_o
);
  logic [4:0] flg;
  assign flg = {boot_rsvd_o, boot_user_o, boot_cache_o, boot_spin_o, boot_idle_o};

  assert_onehot_flags_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(flg));

  assert_aligned_vec_R3: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && flg == '0) |-> fetch_vec_o[ALIGN_BITS-1:0] == '0);

  assert_rom_vec_R4: assert property (@(posedge clk) disable iff (rst)
    (vec_valid_o && flg != '0) |-> fetch_vec_o == ROM_ENTRY);

  assert_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> ($stable(fetch_vec_o) && $stable(flg)));

  assert_valid_hold_R6: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |=> vec_valid_o);

  assert_reset_clear_R6: assert property (@(posedge clk)
    rst |=> (fetch_vec_o == '0 && !vec_valid_o && flg == '0 && !rd_err_o));

  assert_foreign_read_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && req_id_i != CPU_ID) |=> (rd_err_o && rd_data_o == '0));

  assert_cpu_read_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && req_id_i == CPU_ID) |=> !rd_err_o);
endmodule

bind boot_vector_sel boot_vector_sel_chk #(
  .ADDR_W(ADDR_W), .ALIGN_BITS(ALIGN_BITS), .ID_W(ID_W),
  .CPU_ID(CPU_ID), .ROM_ENTRY(ROM_ENTRY)
) i_chk (
  .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .req_id_i(req_id_i),
  .fetch_vec_o(fetch_vec_o), .vec_valid_o(vec_valid_o),
  .boot_idle_o(boot_idle_o), .boot_spin_o(boot_spin_o), .boot_cache_o(boot_cache_o),
  .boot_user_o(boot_user_o), .boot_rsvd_o(boot_rsvd_o),
  .rd_data_o(rd_data_o), .rd_err_o(rd_err_o)
);

// File: tb/test_boot_vector_sel.sv
`timescale 1ns/1ps
module test_boot_vector_sel;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  ctl_mode_i = '0;
  logic [31:0] ctl_addr_i = '0;
  logic        rd_en_i = 1'b0, wr_en_i = 1'b0, rd_sel_i = 1'b0;
  logic [2:0]  req_id_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] fetch_vec_o, rd_data_o;
  logic        vec_valid_o, rd_err_o;
  logic        boot_idle_o, boot_spin_o, boot_cache_o, boot_user_o, boot_rsvd_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0]  exp_mode;
  logic [31:0] exp_addr;

  always #5 clk = ~clk;

  boot_vector_sel i_boot_vector_sel (
    .clk(clk), .rst(rst), .ctl_mode_i(ctl_mode_i), .ctl_addr_i(ctl_addr_i),
    .rd_en_i(rd_en_i), .wr_en_i(wr_en_i), .req_id_i(req_id_i), .rd_sel_i(rd_sel_i),
    .wr_data_i(wr_data_i), .fetch_vec_o(fetch_vec_o), .vec_valid_o(vec_valid_o),
    .boot_idle_o(boot_idle_o), .boot_spin_o(boot_spin_o), .boot_cache_o(boot_cache_o),
    .boot_user_o(boot_user_o), .boot_rsvd_o(boot_rsvd_o),
    .rd_data_o(rd_data_o), .rd_err_o(rd_err_o)
  );

  function automatic logic [31:0] want_vec(input logic [3:0] m, input logic [31:0] a);
    return (m == 4'd0) ? {a[31:10], 10'd0} : 32'h007E_0000;
  endfunction

  function automatic logic [4:0] want_flags(input logic [3:0] m);
    logic [4:0] f = '0;
    if (m >= 4'd1 && m <= 4'd4) f[m-1] = 1'b1;
    else if (m >= 4'd5) f[4] = 1'b1;
    return f;
  endfunction

  function automatic logic [4:0] got_flags();
    return {boot_rsvd_o, boot_user_o, boot_cache_o, boot_spin_o, boot_idle_o};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_outputs(input string tag);
    check(vec_valid_o == 1'b1, {tag, " R2 valid"}, 32'(vec_valid_o), 32'd1);
    check(fetch_vec_o == want_vec(exp_mode, exp_addr),
          (exp_mode == 0) ? {tag, " R3 vector"} : {tag, " R4 vector"},
          fetch_vec_o, want_vec(exp_mode, exp_addr));
    check(got_flags() == want_flags(exp_mode), {tag, " R5 flags"},
          32'(got_flags()), 32'(want_flags(exp_mode)));
  endtask

  // Hold reset with chosen values, release while scrambling the live inputs.
  task automatic boot(input logic [3:0] m, input logic [31:0] a);
    @(negedge clk);
    rst = 1'b1; ctl_mode_i = m; ctl_addr_i = a;
    repeat (2) @(negedge clk);
    check(fetch_vec_o == 0 && !vec_valid_o && got_flags() == 0 && !rd_err_o
          && rd_data_o == 0, "R6 reset state", fetch_vec_o, 32'd0);
    rst = 1'b0;
    ctl_mode_i = 4'($urandom); ctl_addr_i = $urandom;
    exp_mode = m; exp_addr = a;
    @(posedge clk); #1;
    check_outputs("release");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      ctl_mode_i = 4'($urandom); ctl_addr_i = $urandom;
    end
    @(posedge clk); #1;
    check_outputs("R1 frozen");
  endtask

  task automatic rd(input logic [2:0] id, input logic sel);
    logic [31:0] e;
    @(negedge clk);
    rd_en_i = 1'b1; req_id_i = id; rd_sel_i = sel;
    @(posedge clk); #1;
    if (id == 3'd0) begin
      e = sel ? {exp_addr[31:10], 10'd0} : {28'd0, exp_mode};
      check(rd_data_o == e && !rd_err_o, "R7 cpu read", rd_data_o, e);
    end else begin
      check(rd_data_o == 0 && rd_err_o, "R8 foreign read", {rd_data_o[30:0], rd_err_o}, 32'd1);
    end
    @(negedge clk);
    rd_en_i = 1'b0;
    @(posedge clk); #1;
    check(rd_data_o == 0 && !rd_err_o, "R8 R7 idle after read", {rd_data_o[30:0], rd_err_o}, 32'd0);
  endtask

  task automatic wr_burst();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      wr_en_i = 1'b1; req_id_i = 3'($urandom); wr_data_i = $urandom; rd_sel_i = 1'($urandom);
    end
    @(negedge clk);
    wr_en_i = 1'b0;
    @(posedge clk); #1;
    check(fetch_vec_o == want_vec(exp_mode, exp_addr), "R9 vector after writes",
          fetch_vec_o, want_vec(exp_mode, exp_addr));
    rd(3'd0, 1'b0);
    rd(3'd0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // Directed corners
    boot(4'd0, 32'h8000_07FF);
    rd(3'd0, 1'b0); rd(3'd0, 1'b1); rd(3'd5, 1'b1);
    wr_burst();
    boot(4'd0, 32'h0000_0000);
    boot(4'd0, 32'hFFFF_FFFF);
    rd(3'd0, 1'b1);
    for (int m = 1; m < 16; m++) begin
      boot(4'(m), $urandom);
      rd(3'd0, 1'b0);
    end
    rd(3'd7, 1'b0);
    // Constrained random
    for (int i = 0; i < 30; i++) begin
      logic [3:0] m;
      case ($urandom % 4)
        0: m = 4'd0;
        1: m = 4'(1 + $urandom % 4);
        2: m = 4'(5 + $urandom % 11);
        default: m = 4'($urandom);
      endcase
      boot(m, $urandom);
      rd(3'($urandom % 2 == 0 ? 0 : 1 + $urandom % 7), 1'($urandom));
      if (i % 5 == 0) wr_burst();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule